// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Peripheral Ownership

This block is an 8-bit general-purpose I/O port. It holds a data latch and a direction register, and both are reached over a small register bus with a one-bit address. Several pins can be taken over by on-chip peripherals. One pin carries SPI serial data and another carries the SPI slave select. Two pins serve as timer capture/compare channels, and one pin is the UART receive input. The enable and mode inputs of each peripheral decide, pin by pin, whether the peripheral or the port owns that pin.

For every pin the block produces the pad output enable and the pad output value. It also forms the value returned when the data register is read. When a peripheral owns a pin, the peripheral sets the pin's direction and drive. The direction bit still decides whether a read of that bit returns the latch or the synchronized pin level. Writes to the data latch are always accepted, so a pin that a peripheral releases starts driving the value written last.

Top module: `gpio_share_port`

## Requirements
- R1: After reset, the direction register and the data latch are all zero, every pad output enable is 0, and both registers read back as zero.
- R2: A pin not owned by a peripheral is driven (output enable 1) with its latch bit when its direction bit is 1, and it is an input (output enable 0) when its direction bit is 0.
- R3: Reading address 0 returns, per bit, the latch when the direction bit is 1 and the pin level when it is 0. The pin level passes through a two-flop synchronizer, so a pad change appears after the second rising clock edge.
- R4: The SPI data pin (bit 5) is general-purpose while `spi_en` is 0. With `spi_en`=1 and `spi_master`=1 it is an input. With `spi_en`=1 and `spi_master`=0 it is driven with `spi_sdo`.
- R5: The SPI select pin (bit 4) is general-purpose when `spi_en` is 0 or `spi_master` is 1. With `spi_en`=1 and `spi_master`=0 it is an input whatever its direction bit holds.
- R6: Timer channel c (c = 0, 1) uses pin bit 2+c. A mode code of 2'b00 leaves the pin general-purpose. Any non-zero code gives the pin to the timer, which sets output enable from `tmr_oe[c]` and output value from `tmr_do[c]`.
- R7: The UART receive pin (bit 1) is general-purpose while `uart_en` is 0, and it is an input while `uart_en` is 1.
- R8: For pins owned by a peripheral, the direction bit still picks latch (1) or pin (0) as the source of a data-register read.
- R9: A write to the data latch (address 0) updates all bits, including those on owned pins. The written value drives such a pin once its peripheral releases it and its direction bit is 1.
- R10: Address 1 reads and writes the direction register. Bits 0, 6 and 7 are always general-purpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data latch, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| spi_sdo | input | 1 | SPI serial data driven in slave mode |
| tmr_mode | input | 4 | Two 2-bit channel mode codes, channel c at [2c+1:2c] |
| tmr_oe | input | 2 | Timer channel output enables |
| tmr_do | input | 2 | Timer channel output values |
| uart_en | input | 1 | UART receiver enabled |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |

## Verification
Pad enables and values are combinational from the registers and the peripheral inputs. They change in the same cycle as a peripheral input, and one edge after a register write. The bench therefore samples them 1 ns after the writing edge, or after a settle delay for peripheral changes. A pad level reaches a read only after two rising edges, so the bench checks that the old value is still read after one edge and the new value after the second. All stimulus is applied on falling edges, which keeps every sample away from the active edge.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_DIR  = 1'b1
  } port_reg_e;

  // Final pad enable: an owner overrides the direction bit.
  function automatic logic pad_dir(input logic owned, input logic per_oe,
                                   input logic dir_bit);
    return owned ? per_oe : dir_bit;
  endfunction

  // Read source: always chosen by the direction bit, owned or not.
  function automatic logic read_pick(input logic dir_bit, input logic latch_bit,
                                     input logic pin_bit);
    return dir_bit ? latch_bit : pin_bit;
  endfunction

endpackage

// File: rtl/gpio_share_sync.sv
module gpio_share_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pin_raw;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_sync = stage_q[LAST];
endmodule

// File: rtl/gpio_share_regs.sv
module gpio_share_regs
  import gpio_share_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);
  logic wr_latch, wr_dir;
  assign wr_latch = wr_en && (addr == REG_DATA);
  assign wr_dir   = wr_en && (addr == REG_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_latch |=> $stable(latch_q));

  // R10
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_share_owner.sv
module gpio_share_owner #(
  parameter int WIDTH    = 8,
  parameter int NUM_TMR  = 2,
  parameter int SPI_DBIT = 5,
  parameter int SPI_SBIT = 4,
  parameter int TMR_BASE = 2,
  parameter int UART_BIT = 1
) (
  input  logic                      spi_en,
  input  logic                      spi_master,
  input  logic                      spi_sdo,
  input  logic [NUM_TMR-1:0][1:0]   tmr_mode,
  input  logic [NUM_TMR-1:0]        tmr_oe,
  input  logic [NUM_TMR-1:0]        tmr_do,
  input  logic                      uart_en,
  output logic [WIDTH-1:0]          owned,
  output logic [WIDTH-1:0]          per_oe,
  output logic [WIDTH-1:0]          per_do
);
  always_comb begin
    owned  = '0;
    per_oe = '0;
    per_do = '0;
    // SPI data pin: input as master, driven as slave
    owned[SPI_DBIT]  = spi_en;
    per_oe[SPI_DBIT] = spi_en && !spi_master;
    per_do[SPI_DBIT] = spi_sdo;
    // SPI select pin: owned only in slave mode, always an input
    owned[SPI_SBIT]  = spi_en && !spi_master;
    // timer channels
    for (int c = 0; c < NUM_TMR; c++) begin
      owned[TMR_BASE+c]  = |tmr_mode[c];
      per_oe[TMR_BASE+c] = tmr_oe[c];
      per_do[TMR_BASE+c] = tmr_do[c];
    end
    // UART receive pin: input while enabled
    owned[UART_BIT] = uart_en;
  end
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int NUM_TMR  = 2,
  parameter int SYNC_LEN = 2,
  parameter int SPI_DBIT = 5,
  parameter int SPI_SBIT = 4,
  parameter int TMR_BASE = 2,
  parameter int UART_BIT = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_addr,
  input  logic [WIDTH-1:0]       bus_wdata,
  output logic [WIDTH-1:0]       bus_rdata,
  input  logic                   spi_en,
  input  logic                   spi_master,
  input  logic                   spi_sdo,
  input  logic [2*NUM_TMR-1:0]   tmr_mode,
  input  logic [NUM_TMR-1:0]     tmr_oe,
  input  logic [NUM_TMR-1:0]     tmr_do,
  input  logic                   uart_en,
  input  logic [WIDTH-1:0]       pad_in,
  output logic [WIDTH-1:0]       pad_oe,
  output logic [WIDTH-1:0]       pad_out
);
  logic [WIDTH-1:0] latch_q, dir_q, pin_sync;
  logic [WIDTH-1:0] owned, per_oe, per_do, read_data;
  logic [NUM_TMR-1:0][1:0] tmr_mode_a;

  assign tmr_mode_a = tmr_mode;

  gpio_share_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_share_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pad_in), .pin_sync(pin_sync)
  );

  gpio_share_owner #(
    .WIDTH(WIDTH), .NUM_TMR(NUM_TMR), .SPI_DBIT(SPI_DBIT),
    .SPI_SBIT(SPI_SBIT), .TMR_BASE(TMR_BASE), .UART_BIT(UART_BIT)
  ) u_owner (
    .spi_en(spi_en), .spi_master(spi_master), .spi_sdo(spi_sdo),
    .tmr_mode(tmr_mode_a), .tmr_oe(tmr_oe), .tmr_do(tmr_do),
    .uart_en(uart_en), .owned(owned), .per_oe(per_oe), .per_do(per_do)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i]    = pad_dir(owned[i], per_oe[i], dir_q[i]);
      assign pad_out[i]   = owned[i] ? per_do[i] : latch_q[i];
      assign read_data[i] = read_pick(dir_q[i], latch_q[i], pin_sync[i]);
    end
  endgenerate

  assign bus_rdata = (bus_addr == REG_DIR) ? dir_q : read_data;

  // R4
  spi_master_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !pad_oe[SPI_DBIT]);

  // R5
  ss_slave_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> !pad_oe[SPI_SBIT]);

  // R7
  uart_rx_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en |-> !pad_oe[UART_BIT]);

  // R6
  tmr_idle_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_mode[1:0] == 2'b00) |-> (pad_oe[TMR_BASE] == dir_q[TMR_BASE]));

  // R3
  read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_DATA && dir_q[0]) |-> bus_rdata[0] == latch_q[0]);
endmodule

// File: tb/gpio_share_port_test.sv
module gpio_share_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       spi_en = 1'b0, spi_master = 1'b0, spi_sdo = 1'b0;
  logic [3:0] tmr_mode = '0;
  logic [1:0] tmr_oe = '0, tmr_do = '0;
  logic       uart_en = 1'b0;
  logic [7:0] pad_in = '0, pad_oe, pad_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_share_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
    .spi_master(spi_master), .spi_sdo(spi_sdo), .tmr_mode(tmr_mode),
    .tmr_oe(tmr_oe), .tmr_do(tmr_do), .uart_en(uart_en), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic settle_periph();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pad_oe", pad_oe, 8'h00);
    reg_read(1'b1, v); check("R1 dir", v, 8'h00);
    reg_read(1'b0, v); check("R1 data", v, 8'h00);
  endtask

  task automatic t_gpio_out();
    logic [7:0] v;
    reg_write(1'b1, 8'hFF);
    reg_write(1'b0, 8'hA5);
    check("R2 pad_oe", pad_oe, 8'hFF);
    check("R2 pad_out", pad_out, 8'hA5);
    reg_read(1'b0, v); check("R3 read latch", v, 8'hA5);
    reg_read(1'b1, v); check("R10 dir readback", v, 8'hFF);
    reg_write(1'b1, 8'h0F);
    check("R2 half input", pad_oe, 8'h0F);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk); pad_in = 8'h3C;
    @(posedge clk); #1;
    reg_read(1'b0, v); check("R3 one edge", v, 8'h05);
    @(posedge clk); #1;
    reg_read(1'b0, v); check("R3 two edges", v, 8'h35);
  endtask

  task automatic t_spi();
    logic [7:0] v;
    reg_write(1'b1, 8'hFF);
    @(negedge clk); spi_en = 1'b1; spi_master = 1'b0; spi_sdo = 1'b0; #1;
    check("R4/R5 slave oe", pad_oe, 8'hEF);
    check("R4 slave sdo 0", pad_out, 8'h85);
    spi_sdo = 1'b1; #1;
    check("R4 slave sdo 1", pad_out, 8'hA5);
    spi_master = 1'b1; #1;
    check("R4/R5 master oe", pad_oe, 8'hDF);
    spi_master = 1'b0;
    reg_write(1'b1, 8'h00);
    check("R5 slave dir0 oe", pad_oe, 8'h20);
    reg_read(1'b0, v); check("R8 owned read pin", v, 8'h3C);
    reg_write(1'b1, 8'h10);
    reg_read(1'b0, v); check("R8 owned read latch", v, 8'h2C);
    settle_periph(); spi_en = 1'b0; #1;
    check("R4 released", pad_oe, 8'h10);
  endtask

  task automatic t_timer();
    reg_write(1'b1, 8'hFF);
    @(negedge clk); tmr_mode = 4'b0001; tmr_oe = 2'b01; tmr_do = 2'b00; #1;
    check("R6 ch0 drive oe", pad_oe, 8'hFF);
    check("R6 ch0 out", pad_out, 8'hA1);
    tmr_oe = 2'b00; #1;
    check("R6 ch0 input", pad_oe, 8'hFB);
    tmr_mode = 4'b1100; tmr_oe = 2'b10; tmr_do = 2'b10; #1;
    check("R6 ch1 owned oe", pad_oe, 8'hFF);
    check("R6 ch1 out", pad_out, 8'hAD);
    tmr_mode = 4'b0000; #1;
    check("R6 mode00 gpio", pad_out, 8'hA5);
  endtask

  task automatic t_uart();
    @(negedge clk); uart_en = 1'b1; #1;
    check("R7 rx input", pad_oe, 8'hFD);
    reg_write(1'b0, 8'h02);
    check("R9 owned keeps pad", pad_out, 8'h00);
    settle_periph(); uart_en = 1'b0; #1;
    check("R9 release drives", pad_out, 8'h02);
    check("R7 rx gpio", pad_oe, 8'hFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_gpio_out();
    t_sync();
    t_spi();
    reg_write(1'b0, 8'hA5);
    t_timer();
    t_uart();
    finish_run();
  end
endmodule